// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block is a small, fully associative translation buffer for a processor's memory management path. Every entry holds a virtual page number with its own page mask and an 8-bit address-space tag with a global bit. It also holds an even/odd pair of physical frames, and each frame carries its own cacheability code, dirty bit and valid bit. Each cycle a query (virtual page number plus address-space tag) is compared against all entries at once. One clock edge later the block reports whether an entry matched, the lowest matching slot (all-ones when none matched) and that entry's contents in a fixed readback encoding.

Software maintains the table through three operations. An indexed write replaces a whole slot. A flush clears every slot and the refill pointer. A pointer read returns the slot under a refill pointer, and it can step that pointer, wrapping at the table size, so that refill handlers can place new mappings in rotation. A separate combinational check flags virtual addresses that fall in the uncached, strictly ordered window.

Top module: `tlb_assoc`

## Requirements
- R1: A slot matches a query only if its stored page number and the query page number are equal in every bit where the slot's mask is 0. Bits where the mask is 1 are ignored.
- R2: The tag condition holds when the slot's global bit is 1, or when the stored tag equals the query tag. A slot that fails this condition never matches.
- R3: Only slots with at least one frame valid bit set can match. When several slots match, the lowest slot number is reported.
- R4: On a miss, `res_hit` is 0, `res_idx` is all ones (15 for the default sizes) and the three readback words are 0.
- R5: A query result appears on the `res_*` outputs at the clock edge after the query is presented. It reflects the table as it stood before any write or flush taken at that same edge.
- R6: A write to slot n (`wr_en`=1, `wr_idx`<ENTRIES) replaces all fields of slot n. A later query for the old mapping no longer finds slot n.
- R7: A write with `wr_idx` >= ENTRIES changes no slot.
- R8: `flush` clears every slot so that nothing matches, and sets the refill pointer to 0. It takes priority over a write in the same cycle.
- R9: Readback format. `res_vpn_word` = {page number, 3'b000, tag[7:0]}, so the page number starts at bit 11. `res_lo_word` and `res_hi_word` = {frame number, C[2:0], D, V, G}, with G at bit 0, V at bit 1, D at bit 2, C at bits 5:3 and the frame number from bit 6 up. The lo word holds the even frame and the hi word the odd frame.
- R10: With `nxt_rd`=1, the result outputs show the slot at the refill pointer. `res_idx` is the pointer value and `res_hit` is that slot's valid state. If `nxt_adv`=1 as well, the pointer then steps by one modulo ENTRIES. `nxt_adv` without `nxt_rd` does nothing.
- R11: `chk_uncached` is 1 exactly when bits 31 and 29 of `chk_vaddr` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Query virtual page number |
| lk_asid | input | 8 | Query address-space tag |
| nxt_rd | input | 1 | Show the slot at the refill pointer instead of the query result |
| nxt_adv | input | 1 | Step the refill pointer (only together with nxt_rd) |
| wr_en | input | 1 | Indexed write enable |
| wr_idx | input | IDX_W | Slot to write |
| wr_vpn | input | VPN_W | Page number to write |
| wr_mask | input | VPN_W | Page mask to write (1 = ignored bit) |
| wr_asid | input | 8 | Tag to write |
| wr_g | input | 1 | Global bit to write |
| wr_pfn0 | input | PFN_W | Even frame number |
| wr_c0 | input | 3 | Even frame cacheability |
| wr_d0 | input | 1 | Even frame dirty |
| wr_v0 | input | 1 | Even frame valid |
| wr_pfn1 | input | PFN_W | Odd frame number |
| wr_c1 | input | 3 | Odd frame cacheability |
| wr_d1 | input | 1 | Odd frame dirty |
| wr_v1 | input | 1 | Odd frame valid |
| flush | input | 1 | Clear all slots and the refill pointer |
| chk_vaddr | input | 32 | Virtual address for the uncached-window check |
| res_hit | output | 1 | Registered hit (or pointer slot valid) |
| res_idx | output | IDX_W | Registered matching slot, all ones on miss |
| res_vpn_word | output | VPN_W+11 | Registered page/tag readback |
| res_lo_word | output | PFN_W+6 | Registered even-frame readback |
| res_hi_word | output | PFN_W+6 | Registered odd-frame readback |
| res_mask | output | VPN_W | Registered page mask of the reported slot |
| nxt_ptr | output | PTR_W | Current refill pointer |
| chk_uncached | output | 1 | Address lies in the uncached, strictly ordered window |

## Verification
The query path is tried with exact page matches, and with queries that differ only in masked bits or also in unmasked bits, which separates correct masking from plain equality. It is tried with matching and mismatching tags on global and non-global slots, which separates the global bypass from the tag compare. It is also tried with duplicate mappings in several slots, slots that hold no valid frame, and a query taken in the same cycle as the write that replaces its slot. These cases show whether the priority, the valid rule and the one-cycle timing hold. Out-of-range writes, a flush colliding with a write, and pointer stepping past the last slot exercise the maintenance paths. A long random mix of writes, flushes and queries over a small page space is checked against a bench model, so that overlapping masks produce many multiple matches.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ASID_W = 8;
  localparam int CC_W   = 3;
  localparam int VA_W   = 32;
  localparam logic [VA_W-1:0] UNCACHED_PAT = 32'hA000_0000;

  // address falls in the uncached, strictly ordered window
  function automatic logic va_uncached(input logic [VA_W-1:0] va);
    return (va & UNCACHED_PAT) == UNCACHED_PAT;
  endfunction
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell #(
  parameter int VPN_W = 19
) (
  input  logic                       e_valid,
  input  logic [VPN_W-1:0]           e_vpn,
  input  logic [VPN_W-1:0]           e_mask,
  input  logic [tlb_pkg::ASID_W-1:0] e_asid,
  input  logic                       e_g,
  input  logic [VPN_W-1:0]           q_vpn,
  input  logic [tlb_pkg::ASID_W-1:0] q_asid,
  output logic                       hit
);
  function automatic logic vpn_agree(input logic [VPN_W-1:0] a, input logic [VPN_W-1:0] b,
                                     input logic [VPN_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction

  logic page_ok;
  logic tag_ok;

  assign page_ok = vpn_agree(e_vpn, q_vpn, e_mask);
  assign tag_ok  = e_g || (e_asid == q_asid);
  assign hit     = e_valid && page_ok && tag_ok;

  always_comb begin
    if (hit) begin
      AST_HIT_TAG: assert (e_g || e_asid == q_asid); // R2
    end
  end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N     = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  logic [N-1:0] below_mask;
  assign below_mask = (N'(1) << idx) - N'(1);

  always_comb begin
    if (found) begin
      AST_FIRST_LOWEST: assert (((req >> idx) & N'(1)) == N'(1) && (req & below_mask) == '0); // R3
    end else begin
      AST_NONE_SET: assert (req == '0 && idx == '1); // R4
    end
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 4,
  parameter int PTR_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [VPN_W-1:0]           wr_mask,
  input  logic [tlb_pkg::ASID_W-1:0] wr_asid,
  input  logic                       wr_g,
  input  logic [PFN_W-1:0]           wr_pfn0,
  input  logic [tlb_pkg::CC_W-1:0]   wr_c0,
  input  logic                       wr_d0,
  input  logic                       wr_v0,
  input  logic [PFN_W-1:0]           wr_pfn1,
  input  logic [tlb_pkg::CC_W-1:0]   wr_c1,
  input  logic                       wr_d1,
  input  logic                       wr_v1,
  input  logic                       ptr_step,
  output logic [ENTRIES-1:0][VPN_W-1:0]           t_vpn,
  output logic [ENTRIES-1:0][VPN_W-1:0]           t_mask,
  output logic [ENTRIES-1:0][tlb_pkg::ASID_W-1:0] t_asid,
  output logic [ENTRIES-1:0]                      t_g,
  output logic [ENTRIES-1:0][PFN_W-1:0]           t_pfn0,
  output logic [ENTRIES-1:0][tlb_pkg::CC_W-1:0]   t_c0,
  output logic [ENTRIES-1:0]                      t_d0,
  output logic [ENTRIES-1:0]                      t_v0,
  output logic [ENTRIES-1:0][PFN_W-1:0]           t_pfn1,
  output logic [ENTRIES-1:0][tlb_pkg::CC_W-1:0]   t_c1,
  output logic [ENTRIES-1:0]                      t_d1,
  output logic [ENTRIES-1:0]                      t_v1,
  output logic [PTR_W-1:0]                        ptr
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic wr_in_range;
  logic wr_accept;
  logic clear_all;

  assign wr_in_range = wr_idx < IDX_W'(ENTRIES);
  assign clear_all   = flush;
  assign wr_accept   = wr_en && wr_in_range && !clear_all;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic slot_sel;
    assign slot_sel = wr_accept && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n || clear_all) begin
        t_vpn[i]  <= '0;
        t_mask[i] <= '0;
        t_asid[i] <= '0;
        t_g[i]    <= 1'b0;
        t_pfn0[i] <= '0;
        t_c0[i]   <= '0;
        t_d0[i]   <= 1'b0;
        t_v0[i]   <= 1'b0;
        t_pfn1[i] <= '0;
        t_c1[i]   <= '0;
        t_d1[i]   <= 1'b0;
        t_v1[i]   <= 1'b0;
      end else if (slot_sel) begin
        t_vpn[i]  <= wr_vpn;
        t_mask[i] <= wr_mask;
        t_asid[i] <= wr_asid;
        t_g[i]    <= wr_g;
        t_pfn0[i] <= wr_pfn0;
        t_c0[i]   <= wr_c0;
        t_d0[i]   <= wr_d0;
        t_v0[i]   <= wr_v0;
        t_pfn1[i] <= wr_pfn1;
        t_c1[i]   <= wr_c1;
        t_d1[i]   <= wr_d1;
        t_v1[i]   <= wr_v1;
      end
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && !(wr_en && wr_idx == IDX_W'(i)) |=>
      $stable({t_vpn[i], t_mask[i], t_asid[i], t_g[i], t_pfn0[i], t_v0[i], t_pfn1[i], t_v1[i]})); // R7
    AST_SLOT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !t_v0[i] && !t_v1[i] && t_vpn[i] == '0); // R8
    AST_SLOT_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      !flush && wr_en && wr_idx == IDX_W'(i) |=> t_vpn[i] == $past(wr_vpn) && t_asid[i] == $past(wr_asid)); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_all) ptr <= '0;
    else if (ptr_step)       ptr <= (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
  end

  AST_PTR_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ptr == '0); // R8
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && ptr_step && ptr == PTR_LAST |=> ptr == '0); // R10
  AST_PTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !flush && !ptr_step |=> $stable(ptr)); // R10
  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PTR_LAST); // R10
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  localparam int PTR_W  = $clog2(ENTRIES),
  localparam int IDX_W  = PTR_W + 1,
  localparam int HALF_W = PFN_W + 6,
  localparam int VW_W   = VPN_W + 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VPN_W-1:0]           lk_vpn,
  input  logic [tlb_pkg::ASID_W-1:0] lk_asid,
  input  logic                       nxt_rd,
  input  logic                       nxt_adv,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VPN_W-1:0]           wr_vpn,
  input  logic [VPN_W-1:0]           wr_mask,
  input  logic [tlb_pkg::ASID_W-1:0] wr_asid,
  input  logic                       wr_g,
  input  logic [PFN_W-1:0]           wr_pfn0,
  input  logic [tlb_pkg::CC_W-1:0]   wr_c0,
  input  logic                       wr_d0,
  input  logic                       wr_v0,
  input  logic [PFN_W-1:0]           wr_pfn1,
  input  logic [tlb_pkg::CC_W-1:0]   wr_c1,
  input  logic                       wr_d1,
  input  logic                       wr_v1,
  input  logic                       flush,
  input  logic [tlb_pkg::VA_W-1:0]   chk_vaddr,
  output logic                       res_hit,
  output logic [IDX_W-1:0]           res_idx,
  output logic [VW_W-1:0]            res_vpn_word,
  output logic [HALF_W-1:0]          res_lo_word,
  output logic [HALF_W-1:0]          res_hi_word,
  output logic [VPN_W-1:0]           res_mask,
  output logic [PTR_W-1:0]           nxt_ptr,
  output logic                       chk_uncached
);
  import tlb_pkg::*;

  function automatic logic [HALF_W-1:0] pack_half(input logic [PFN_W-1:0] pfn, input logic [CC_W-1:0] c,
                                                  input logic d, input logic v, input logic g);
    return {pfn, c, d, v, g};
  endfunction

  function automatic logic [VW_W-1:0] pack_vpn(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid);
    return {vpn, 3'b000, asid};
  endfunction

  logic [ENTRIES-1:0][VPN_W-1:0]  t_vpn, t_mask;
  logic [ENTRIES-1:0][ASID_W-1:0] t_asid;
  logic [ENTRIES-1:0]             t_g, t_d0, t_v0, t_d1, t_v1;
  logic [ENTRIES-1:0][PFN_W-1:0]  t_pfn0, t_pfn1;
  logic [ENTRIES-1:0][CC_W-1:0]   t_c0, t_c1;
  logic [ENTRIES-1:0]             match_vec;
  logic                           any_match;
  logic [IDX_W-1:0]               first_idx;
  logic                           ptr_step;

  assign ptr_step = nxt_rd && nxt_adv;

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_c0(wr_c0), .wr_d0(wr_d0), .wr_v0(wr_v0),
    .wr_pfn1(wr_pfn1), .wr_c1(wr_c1), .wr_d1(wr_d1), .wr_v1(wr_v1),
    .ptr_step(ptr_step),
    .t_vpn(t_vpn), .t_mask(t_mask), .t_asid(t_asid), .t_g(t_g),
    .t_pfn0(t_pfn0), .t_c0(t_c0), .t_d0(t_d0), .t_v0(t_v0),
    .t_pfn1(t_pfn1), .t_c1(t_c1), .t_d1(t_d1), .t_v1(t_v1),
    .ptr(nxt_ptr)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    tlb_match_cell #(.VPN_W(VPN_W)) u_cell (
      .e_valid(t_v0[i] || t_v1[i]),
      .e_vpn(t_vpn[i]), .e_mask(t_mask[i]), .e_asid(t_asid[i]), .e_g(t_g[i]),
      .q_vpn(lk_vpn), .q_asid(lk_asid),
      .hit(match_vec[i])
    );
  end

  tlb_first_set #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req(match_vec), .found(any_match), .idx(first_idx)
  );

  // slot chosen for readback and the result it produces
  logic [PTR_W-1:0]  sel_slot;
  logic              sel_show;
  logic              nx_hit;
  logic [IDX_W-1:0]  nx_idx;

  always_comb begin
    if (nxt_rd) begin
      sel_slot = nxt_ptr;
      sel_show = 1'b1;
      nx_hit   = t_v0[nxt_ptr] || t_v1[nxt_ptr];
      nx_idx   = IDX_W'(nxt_ptr);
    end else begin
      sel_slot = PTR_W'(first_idx);
      sel_show = any_match;
      nx_hit   = any_match;
      nx_idx   = first_idx;
    end
  end

  logic res_from_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_hit      <= 1'b0;
      res_idx      <= '1;
      res_vpn_word <= '0;
      res_lo_word  <= '0;
      res_hi_word  <= '0;
      res_mask     <= '0;
      res_from_ptr <= 1'b0;
    end else begin
      res_hit      <= nx_hit;
      res_idx      <= nx_idx;
      res_from_ptr <= nxt_rd;
      if (sel_show) begin
        res_vpn_word <= pack_vpn(t_vpn[sel_slot], t_asid[sel_slot]);
        res_lo_word  <= pack_half(t_pfn0[sel_slot], t_c0[sel_slot], t_d0[sel_slot], t_v0[sel_slot], t_g[sel_slot]);
        res_hi_word  <= pack_half(t_pfn1[sel_slot], t_c1[sel_slot], t_d1[sel_slot], t_v1[sel_slot], t_g[sel_slot]);
        res_mask     <= t_mask[sel_slot];
      end else begin
        res_vpn_word <= '0;
        res_lo_word  <= '0;
        res_hi_word  <= '0;
        res_mask     <= '0;
      end
    end
  end

  assign chk_uncached = va_uncached(chk_vaddr);

  always_comb begin
    AST_UNCACHED_WINDOW: assert (chk_uncached == (chk_vaddr[31] && chk_vaddr[29])); // R11
  end

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !res_from_ptr && !res_hit |-> res_idx == '1 && res_lo_word == '0); // R4
  AST_HIT_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !res_from_ptr && res_hit |-> (res_lo_word[1] || res_hi_word[1]) && res_idx < IDX_W'(ENTRIES)); // R3
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_rd && !any_match |=> !res_hit); // R5
  AST_GLOBAL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> res_lo_word[0] == res_hi_word[0]); // R9
endmodule

// File: tb/tlb_assoc_test.sv
module tlb_assoc_test;
  localparam int ENTRIES = 8;
  localparam int VPN_W   = 19;
  localparam int PFN_W   = 20;
  localparam int IDX_W   = 4;
  localparam int PTR_W   = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [VPN_W-1:0] lk_vpn;
  logic [7:0] lk_asid;
  logic nxt_rd, nxt_adv, wr_en, wr_g, wr_d0, wr_v0, wr_d1, wr_v1, flush;
  logic [IDX_W-1:0] wr_idx;
  logic [VPN_W-1:0] wr_vpn, wr_mask;
  logic [7:0] wr_asid;
  logic [PFN_W-1:0] wr_pfn0, wr_pfn1;
  logic [2:0] wr_c0, wr_c1;
  logic [31:0] chk_vaddr;
  logic res_hit, chk_uncached;
  logic [IDX_W-1:0] res_idx;
  logic [VPN_W+10:0] res_vpn_word;
  logic [PFN_W+5:0] res_lo_word, res_hi_word;
  logic [VPN_W-1:0] res_mask;
  logic [PTR_W-1:0] nxt_ptr;

  always #4 clk = ~clk;

  tlb_assoc uut (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .nxt_rd(nxt_rd), .nxt_adv(nxt_adv),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_mask(wr_mask), .wr_asid(wr_asid), .wr_g(wr_g),
    .wr_pfn0(wr_pfn0), .wr_c0(wr_c0), .wr_d0(wr_d0), .wr_v0(wr_v0),
    .wr_pfn1(wr_pfn1), .wr_c1(wr_c1), .wr_d1(wr_d1), .wr_v1(wr_v1),
    .flush(flush), .chk_vaddr(chk_vaddr),
    .res_hit(res_hit), .res_idx(res_idx), .res_vpn_word(res_vpn_word), .res_lo_word(res_lo_word),
    .res_hi_word(res_hi_word), .res_mask(res_mask), .nxt_ptr(nxt_ptr), .chk_uncached(chk_uncached)
  );

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;

  // bench model of the table
  logic [VPN_W-1:0] m_vpn [ENTRIES];
  logic [VPN_W-1:0] m_mask[ENTRIES];
  logic [7:0]       m_asid[ENTRIES];
  logic             m_g[ENTRIES], m_d0[ENTRIES], m_v0[ENTRIES], m_d1[ENTRIES], m_v1[ENTRIES];
  logic [PFN_W-1:0] m_pfn0[ENTRIES], m_pfn1[ENTRIES];
  logic [2:0]       m_c0[ENTRIES], m_c1[ENTRIES];
  int m_ptr = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int i = 0; i < ENTRIES; i++) begin
      m_vpn[i] = '0; m_mask[i] = '0; m_asid[i] = '0; m_g[i] = 0;
      m_pfn0[i] = '0; m_c0[i] = '0; m_d0[i] = 0; m_v0[i] = 0;
      m_pfn1[i] = '0; m_c1[i] = '0; m_d1[i] = 0; m_v1[i] = 0;
    end
    m_ptr = 0;
  endfunction

  // lowest slot satisfying the mask, tag and valid rules, or -1
  function automatic int model_find(logic [VPN_W-1:0] v, logic [7:0] a);
    for (int i = 0; i < ENTRIES; i++) begin
      logic page_same, tag_same;
      page_same = 1'b1;
      for (int b = 0; b < VPN_W; b++)
        if (!m_mask[i][b] && (m_vpn[i][b] != v[b])) page_same = 1'b0;
      tag_same = m_g[i] || (m_asid[i] == a);
      if ((m_v0[i] || m_v1[i]) && page_same && tag_same) return i;
    end
    return -1;
  endfunction

  function automatic logic [63:0] exp_vw(int i);
    return (64'(m_vpn[i]) << 11) | 64'(m_asid[i]);
  endfunction
  function automatic logic [63:0] exp_lo(int i);
    return (64'(m_pfn0[i]) << 6) | (64'(m_c0[i]) << 3) | (64'(m_d0[i]) << 2) | (64'(m_v0[i]) << 1) | 64'(m_g[i]);
  endfunction
  function automatic logic [63:0] exp_hi(int i);
    return (64'(m_pfn1[i]) << 6) | (64'(m_c1[i]) << 3) | (64'(m_d1[i]) << 2) | (64'(m_v1[i]) << 1) | 64'(m_g[i]);
  endfunction

  task automatic set_wr(int idx, logic [VPN_W-1:0] v, logic [VPN_W-1:0] msk, logic [7:0] a, logic g,
                        logic v0, logic v1);
    wr_idx = IDX_W'(idx); wr_vpn = v; wr_mask = msk; wr_asid = a; wr_g = g;
    wr_pfn0 = PFN_W'($urandom); wr_c0 = 3'($urandom); wr_d0 = 1'($urandom); wr_v0 = v0;
    wr_pfn1 = PFN_W'($urandom); wr_c1 = 3'($urandom); wr_d1 = 1'($urandom); wr_v1 = v1;
  endtask

  function automatic void model_write();
    int i;
    i = int'(wr_idx);
    if (i < ENTRIES) begin
      m_vpn[i] = wr_vpn; m_mask[i] = wr_mask; m_asid[i] = wr_asid; m_g[i] = wr_g;
      m_pfn0[i] = wr_pfn0; m_c0[i] = wr_c0; m_d0[i] = wr_d0; m_v0[i] = wr_v0;
      m_pfn1[i] = wr_pfn1; m_c1[i] = wr_c1; m_d1[i] = wr_d1; m_v1[i] = wr_v1;
    end
  endfunction

  task automatic do_write(int idx, logic [VPN_W-1:0] v, logic [VPN_W-1:0] msk, logic [7:0] a, logic g,
                          logic v0, logic v1);
    @(negedge clk);
    set_wr(idx, v, msk, a, g, v0, v1);
    wr_en = 1'b1;
    @(posedge clk); #1;
    model_write();
    wr_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(posedge clk); #1;
    model_clear();
    flush = 1'b0;
  endtask

  task automatic expect_result(string tag, int e);
    if (e >= 0) begin
      check({tag, " hit"}, 64'(res_hit), 64'd1);
      check({tag, " idx"}, 64'(res_idx), 64'(e));
      check({tag, " vpn word (R9)"}, 64'(res_vpn_word), exp_vw(e));
      check({tag, " lo word (R9)"}, 64'(res_lo_word), exp_lo(e));
      check({tag, " hi word (R9)"}, 64'(res_hi_word), exp_hi(e));
      check({tag, " mask"}, 64'(res_mask), 64'(m_mask[e]));
    end else begin
      check({tag, " miss hit (R4)"}, 64'(res_hit), 64'd0);
      check({tag, " miss idx (R4)"}, 64'(res_idx), 64'hF);
      check({tag, " miss word (R4)"}, 64'(res_lo_word), 64'd0);
    end
  endtask

  task automatic do_look(logic [VPN_W-1:0] v, logic [7:0] a, string tag);
    int e;
    @(negedge clk);
    lk_vpn = v; lk_asid = a; nxt_rd = 1'b0;
    e = model_find(v, a);
    @(posedge clk); #1;
    expect_result(tag, e);
  endtask

  task automatic do_ptr(logic adv, string tag);
    int p;
    @(negedge clk);
    nxt_rd = 1'b1; nxt_adv = adv;
    p = m_ptr;
    @(posedge clk); #1;
    check({tag, " ptr hit R10"}, 64'(res_hit), 64'(m_v0[p] || m_v1[p]));
    check({tag, " ptr idx R10"}, 64'(res_idx), 64'(p));
    check({tag, " ptr lo R10"}, 64'(res_lo_word), exp_lo(p));
    if (adv) m_ptr = (m_ptr + 1) % ENTRIES;
    check({tag, " ptr value R10"}, 64'(nxt_ptr), 64'(m_ptr));
    nxt_rd = 1'b0; nxt_adv = 1'b0;
  endtask

  task automatic chk_va(logic [31:0] va, logic exp);
    chk_vaddr = va;
    #1;
    check("R11 uncached window", 64'(chk_uncached), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    int e;
    seed_dummy = $urandom(32'd2024);
    rst_n = 0; lk_vpn = '0; lk_asid = '0; nxt_rd = 0; nxt_adv = 0; wr_en = 0; flush = 0;
    chk_vaddr = '0;
    set_wr(0, '0, '0, '0, 0, 0, 0);
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check("reset hit R4", 64'(res_hit), 64'd0);
    check("reset idx R4", 64'(res_idx), 64'hF);
    check("reset ptr R8", 64'(nxt_ptr), 64'd0);
    @(negedge clk); rst_n = 1;

    // R2: tag compare and global bypass
    do_write(0, 19'h100, '0, 8'd5, 0, 1, 0);
    do_look(19'h100, 8'd5, "R2 own tag");
    do_look(19'h100, 8'd6, "R2 other tag");
    do_write(1, 19'h100, '0, 8'd9, 1, 0, 1);
    do_look(19'h100, 8'd6, "R2 global");
    // R3: lowest wins
    do_look(19'h100, 8'd5, "R3 lowest");
    // R1: masked bits ignored
    do_write(2, 19'h200, 19'h00F, 8'd1, 0, 0, 1);
    do_look(19'h20A, 8'd1, "R1 masked diff");
    do_look(19'h210, 8'd1, "R1 unmasked diff");
    // R3: invalid slot never hits
    do_write(3, 19'h300, '0, 8'd1, 1, 0, 0);
    do_look(19'h300, 8'd1, "R3 invalid");
    // R6: replace
    do_write(2, 19'h400, '0, 8'd1, 0, 1, 1);
    do_look(19'h20A, 8'd1, "R6 old gone");
    do_look(19'h400, 8'd1, "R6 new found");
    // R7: out-of-range writes
    do_write(8, 19'h500, '0, 8'd1, 1, 1, 1);
    do_write(15, 19'h500, '0, 8'd1, 1, 1, 1);
    do_look(19'h500, 8'd1, "R7 out of range");
    do_look(19'h400, 8'd1, "R7 neighbours kept");

    // R5: query in the same cycle as a write replacing the matching slot
    @(negedge clk);
    lk_vpn = 19'h100; lk_asid = 8'd5;
    e = model_find(19'h100, 8'd5);
    set_wr(0, 19'h600, '0, 8'd5, 1, 1, 0);
    wr_en = 1'b1;
    @(posedge clk); #1;
    expect_result("R5 pre-write view", e);
    model_write();
    wr_en = 1'b0;
    do_look(19'h100, 8'd5, "R5 next cycle");

    // R10: pointer
    do_ptr(0, "R10 no step");
    @(negedge clk); nxt_adv = 1'b1;
    @(posedge clk); #1;
    check("R10 adv alone ignored", 64'(nxt_ptr), 64'(m_ptr));
    nxt_adv = 1'b0;
    for (int k = 0; k < ENTRIES + 2; k++) do_ptr(1, "R10 step");

    // R8: flush against write
    @(negedge clk);
    flush = 1'b1; wr_en = 1'b1;
    set_wr(4, 19'h700, '0, 8'd2, 1, 1, 1);
    @(posedge clk); #1;
    model_clear();
    flush = 1'b0; wr_en = 1'b0;
    check("R8 ptr cleared", 64'(nxt_ptr), 64'd0);
    do_look(19'h700, 8'd2, "R8 flush beats write");
    do_look(19'h400, 8'd1, "R8 flushed slot");

    // R11
    chk_va(32'hA000_0000, 1);
    chk_va(32'h8000_0000, 0);
    chk_va(32'h2000_0000, 0);
    chk_va(32'hBFC0_1234, 1);
    chk_va(32'hFFFF_FFFF, 1);
    chk_va(32'h5FFF_FFFF, 0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 3) begin
        do_flush();
      end else if (op < 40) begin
        logic [VPN_W-1:0] mk;
        case ($urandom % 4)
          0: mk = '0;
          1: mk = 19'h1;
          2: mk = 19'h3;
          default: mk = 19'h7;
        endcase
        do_write(int'($urandom % 10), VPN_W'($urandom % 32), mk, 8'($urandom % 4), 1'($urandom % 4 == 0),
                 1'($urandom), 1'($urandom));
      end else if (op < 45) begin
        do_ptr(1'($urandom), "R10 random");
      end else begin
        do_look(VPN_W'($urandom % 32), 8'($urandom % 4), "R1 R2 R3 random");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule